// File: doc/BRIEF.md
# Multi-lane SPI display panel transmitter

This block turns a stream of command and pixel words into the serial waveform a small display panel expects. It drives an active-low chip select, a serial clock, a data/command line and four data lanes. Four link modes are supported. Two are single-lane: a 3-wire mode, where the data/command flag travels in-band ahead of every word, and a 4-wire mode, where the flag travels on its own line. The other two are multi-lane: dual and quad, which spread pixel data over two or four lanes while commands stay on lane 0.

Words arrive through a valid/ready handshake with a flag that marks each word as a command or as pixel data. Link mode, pixel width, clock polarity and phase, and the chip-select setup and hold delays are static settings that change only while chip select is high. The serial clock runs at half the core clock. Chip select stays low across words that are presented back to back, and it is released once the input goes idle and the hold delay has elapsed.

Top module: `spi_panel_tx`

## Requirements
- R1: Idle state: after reset and whenever no transfer is active, `cs_n`=1, `sclk`=`cfg_cpol`, `sd`=0, `dc`=1 and `in_ready`=1.
- R2: In 3-wire mode (`cfg_mode`=0), the bits go out on lane 0, most significant first. A command is a 0 flag followed by `in_data[7:0]` (9 bits). A data word is a 1 flag followed by `in_data[W-1:0]` (W+1 bits).
- R3: In 4-wire mode (`cfg_mode`=1), a command is `in_data[7:0]` (8 bits) and a data word is `in_data[W-1:0]` (W bits), both on lane 0 with no flag. In every mode, `dc` is 0 for each bit of a command word and 1 for each bit of a data word.
- R4: In dual mode (`cfg_mode`=2), commands use the 9-bit flagged framing on lane 0 only. Data is `in_data[W-1:0]` sent as ceil(W/2) beats, with `sd[1]` carrying the higher bit of each pair and zero padding at the end.
- R5: In quad mode (`cfg_mode`=3), a command is all 32 bits of `in_data` on lane 0: an 8-bit header in [31:24], then a 24-bit command. Data is sent as ceil(W/4) beats, with `sd[3]` carrying the most significant bit of each beat and zero padding at the end.
- R6: `cfg_fmt` selects the pixel width W: 0→3, 1→8, 2→12, 3→16, 4→18, 5/6/7→24. Bits of `in_data` at W and above are ignored.
- R7: The serial clock period is 2 core cycles and its idle level is `cfg_cpol`. With `cfg_cpha`=0 the panel samples on the first clock edge of each bit, with `cfg_cpha`=1 on the second. Data changes only on the opposite edge. Within one chip-select window, consecutive sampling edges are exactly 2 cycles apart.
- R8: The time from `cs_n` falling to the first `sclk` transition is 2·`cfg_lead` + (1 if `cfg_cpha`=0, else 0) core cycles.
- R9: The time from the last `sclk` transition to `cs_n` rising is 2·`cfg_trail` + (1 if `cfg_cpha`=1, else 0) core cycles.
- R10: Words accepted back to back share one chip-select window. `cs_n` falls once per burst.
- R11: `in_ready` is high while chip select is low only in the final core cycle of each word's last bit, once per word.
- R12: Lanes above the active lane count are 0 during a transfer, and `sd` is 0 while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Link mode: 0 3-wire, 1 4-wire, 2 dual, 3 quad |
| cfg_fmt | input | 3 | Pixel width select |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sample on second edge when 1 |
| cfg_lead | input | 3 | Chip-select setup delay in serial periods |
| cfg_trail | input | 3 | Chip-select hold delay in serial periods |
| in_valid | input | 1 | Word present |
| in_is_cmd | input | 1 | Word is a command |
| in_data | input | 32 | Command or pixel word |
| in_ready | output | 1 | Word accepted when high with in_valid |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| dc | output | 1 | Data/command line, 0 for command |
| sd | output | 4 | Serial data lanes |

## Verification
The framing is tried in every link mode with lone commands and lone pixel words, with command-then-data bursts, and with random mixes of up to four words in random formats. These patterns separate errors in flag insertion, frame length, lane ordering and padding. Running every pixel width through the 4-wire mode isolates the width decode from lane splitting. Odd widths on dual and quad links expose padding errors. Sweeping all four clock polarity and phase pairs, together with the extreme setup and hold delays of 0 and 7, separates errors at the sampling edge from off-by-one errors in the chip-select timing. Random data carries garbage above the pixel width, so a leak of unused bits shows up on the wire.

// File: rtl/spi_panel_pkg.sv
package spi_panel_pkg;

  typedef enum logic [1:0] {
    LINK_3W   = 2'd0,
    LINK_4W   = 2'd1,
    LINK_DUAL = 2'd2,
    LINK_QUAD = 2'd3
  } link_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } seq_state_e;

  // pixel width on the wire for each format code
  function automatic logic [5:0] px_width(input logic [2:0] fmt);
    logic [5:0] w;
    case (fmt)
      3'd0:    w = 6'd3;
      3'd1:    w = 6'd8;
      3'd2:    w = 6'd12;
      3'd3:    w = 6'd16;
      3'd4:    w = 6'd18;
      default: w = 6'd24;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/spi_word_loader.sv
module spi_word_loader
  import spi_panel_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BEAT_W = 6,
  parameter int LANE_W = 3
) (
  input  logic [1:0]        mode,
  input  logic [2:0]        fmt,
  input  logic              is_cmd,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] sh,
  output logic [BEAT_W-1:0] beats,
  output logic [LANE_W-1:0] lanes
);
  logic [5:0]        w;
  logic [WORD_W-1:0] pix_al;

  always_comb begin
    w      = px_width(fmt);
    // left-align the pixel so its MSB leaves first
    pix_al = data << (WORD_W - int'(w));
    sh     = '0;
    beats  = '0;
    lanes  = LANE_W'(1);
    if (is_cmd) begin
      case (link_mode_e'(mode))
        LINK_4W: begin
          sh    = {data[7:0], {(WORD_W-8){1'b0}}};
          beats = BEAT_W'(8);
        end
        LINK_QUAD: begin
          // header and command fill the whole word
          sh    = data;
          beats = BEAT_W'(WORD_W);
        end
        default: begin
          sh    = {1'b0, data[7:0], {(WORD_W-9){1'b0}}};
          beats = BEAT_W'(9);
        end
      endcase
    end else begin
      case (link_mode_e'(mode))
        LINK_3W: begin
          sh    = {1'b1, pix_al[WORD_W-1:1]};
          beats = BEAT_W'(w) + BEAT_W'(1);
        end
        LINK_4W: begin
          sh    = pix_al;
          beats = BEAT_W'(w);
        end
        LINK_DUAL: begin
          sh    = pix_al;
          lanes = LANE_W'(2);
          beats = BEAT_W'((w + 6'd1) >> 1);
        end
        default: begin
          sh    = pix_al;
          lanes = LANE_W'(4);
          beats = BEAT_W'((w + 6'd3) >> 2);
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_panel_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BEAT_W = 6,
  parameter int LANE_W = 3,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              ld_is_cmd,
  input  logic [WORD_W-1:0] ld_sh,
  input  logic [BEAT_W-1:0] ld_beats,
  input  logic [LANE_W-1:0] ld_lanes,
  input  logic [DLY_W-1:0]  lead,
  input  logic [DLY_W-1:0]  trail,
  output logic              in_ready,
  output logic              cs_n,
  output logic              shifting,
  output logic              ph,
  output logic [WORD_W-1:0] sh,
  output logic [LANE_W-1:0] lanes,
  output logic              is_cmd
);
  localparam int CNT_W = DLY_W + 1;

  seq_state_e        state_q, state_d;
  logic              ph_q, ph_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [CNT_W-1:0]  dly_q, dly_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [LANE_W-1:0] lanes_q, lanes_d;
  logic              cmd_q, cmd_d;
  logic              take, step, last;
  logic              word_en, ctl_en;

  always_comb begin
    state_d  = state_q;
    ph_d     = ph_q;
    beat_d   = beat_q;
    dly_d    = dly_q;
    sh_d     = sh_q;
    lanes_d  = lanes_q;
    cmd_d    = cmd_q;
    in_ready = 1'b0;
    take     = 1'b0;
    step     = 1'b0;
    last     = (beat_q == BEAT_W'(1));
    case (state_q)
      ST_IDLE: begin
        in_ready = 1'b1;
        if (in_valid) begin
          take = 1'b1;
          ph_d = 1'b0;
          if (lead != '0) begin
            state_d = ST_LEAD;
            dly_d   = {lead, 1'b0} - CNT_W'(1);
          end else begin
            state_d = ST_SHIFT;
          end
        end
      end
      ST_LEAD: begin
        if (dly_q == '0) begin
          state_d = ST_SHIFT;
          ph_d    = 1'b0;
        end else begin
          dly_d = dly_q - CNT_W'(1);
        end
      end
      ST_SHIFT: begin
        ph_d = ~ph_q;
        if (ph_q) begin
          if (last) begin
            in_ready = 1'b1;
            if (in_valid) begin
              take = 1'b1;
            end else if (trail != '0) begin
              state_d = ST_TRAIL;
              dly_d   = {trail, 1'b0} - CNT_W'(1);
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            step = 1'b1;
          end
        end
      end
      default: begin
        if (dly_q == '0) state_d = ST_IDLE;
        else             dly_d   = dly_q - CNT_W'(1);
      end
    endcase
    if (step) begin
      beat_d = beat_q - BEAT_W'(1);
      sh_d   = sh_q << lanes_q;
    end
    if (take) begin
      sh_d    = ld_sh;
      beat_d  = ld_beats;
      lanes_d = ld_lanes;
      cmd_d   = ld_is_cmd;
    end
  end

  assign word_en = take | step;
  assign ctl_en  = (state_q != ST_IDLE) | in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      dly_q   <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      ph_q    <= ph_d;
      dly_q   <= dly_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      sh_q    <= '0;
      lanes_q <= LANE_W'(1);
      cmd_q   <= 1'b0;
    end else if (word_en) begin
      beat_q  <= beat_d;
      sh_q    <= sh_d;
      lanes_q <= lanes_d;
      cmd_q   <= cmd_d;
    end
  end

  assign cs_n     = (state_q == ST_IDLE);
  assign shifting = (state_q == ST_SHIFT);
  assign ph       = ph_q;
  assign sh       = sh_q;
  assign lanes    = lanes_q;
  assign is_cmd   = cmd_q;
endmodule

// File: rtl/spi_lane_drive.sv
module spi_lane_drive #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 3
) (
  input  logic              active,
  input  logic [LANE_W-1:0] lanes,
  input  logic [WORD_W-1:0] sh,
  output logic [LANES-1:0]  sd
);
  localparam int IDX_W = $clog2(WORD_W);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic             lane_bit;
    logic [IDX_W-1:0] idx;
    always_comb begin
      // lane j takes bit j of the top 'lanes' bits of the shifter
      idx      = IDX_W'(WORD_W - int'(lanes) + j);
      lane_bit = 1'b0;
      if (active && (j < int'(lanes))) lane_bit = sh[idx];
    end
    assign sd[j] = lane_bit;
  end
endmodule

// File: rtl/spi_panel_tx.sv
module spi_panel_tx #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [2:0]        cfg_fmt,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DLY_W-1:0]  cfg_lead,
  input  logic [DLY_W-1:0]  cfg_trail,
  input  logic              in_valid,
  input  logic              in_is_cmd,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              cs_n,
  output logic              sclk,
  output logic              dc,
  output logic [LANES-1:0]  sd
);
  localparam int BEAT_W = $clog2(WORD_W + 2);
  localparam int LANE_W = $clog2(LANES) + 1;

  logic              rst_n_int;
  logic [WORD_W-1:0] ld_sh, sh;
  logic [BEAT_W-1:0] ld_beats;
  logic [LANE_W-1:0] ld_lanes, lanes;
  logic              shifting, ph, is_cmd;

  spi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  spi_word_loader #(.WORD_W(WORD_W), .BEAT_W(BEAT_W), .LANE_W(LANE_W)) u_load (
    .mode   (cfg_mode),
    .fmt    (cfg_fmt),
    .is_cmd (in_is_cmd),
    .data   (in_data),
    .sh     (ld_sh),
    .beats  (ld_beats),
    .lanes  (ld_lanes)
  );

  spi_seq #(.WORD_W(WORD_W), .BEAT_W(BEAT_W), .LANE_W(LANE_W), .DLY_W(DLY_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .in_valid  (in_valid),
    .ld_is_cmd (in_is_cmd),
    .ld_sh     (ld_sh),
    .ld_beats  (ld_beats),
    .ld_lanes  (ld_lanes),
    .lead      (cfg_lead),
    .trail     (cfg_trail),
    .in_ready  (in_ready),
    .cs_n      (cs_n),
    .shifting  (shifting),
    .ph        (ph),
    .sh        (sh),
    .lanes     (lanes),
    .is_cmd    (is_cmd)
  );

  spi_lane_drive #(.WORD_W(WORD_W), .LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .active (shifting),
    .lanes  (lanes),
    .sh     (sh),
    .sd     (sd)
  );

  // first half of a bit holds the idle level for phase 0, the active level for phase 1
  assign sclk = shifting ? (cfg_cpol ^ (cfg_cpha ? ~ph : ph)) : cfg_cpol;
  assign dc   = cs_n | ~is_cmd;
endmodule

// File: rtl/spi_panel_tx_chk.sv
module spi_panel_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       cfg_cpol,
  input logic       cfg_cpha,
  input logic       in_valid,
  input logic       in_ready,
  input logic       cs_n,
  input logic       sclk,
  input logic       dc,
  input logic [3:0] sd
);
  assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dc && in_ready));

  assert_idle_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == cfg_cpol));

  assert_next_word_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cs_n) |=> (sclk == (cfg_cpol ^ cfg_cpha)));

  assert_hold_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !cs_n) |=> !cs_n);

  assert_idle_lanes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sd == 4'b0000));

  assert_single_lane_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cfg_mode[1]) |-> (sd[3:1] == 3'b000));

  assert_dual_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cfg_mode == 2'd2) |-> (sd[3:2] == 2'b00));
endmodule

bind spi_panel_tx spi_panel_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_mode (cfg_mode),
  .cfg_cpol (cfg_cpol),
  .cfg_cpha (cfg_cpha),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .dc       (dc),
  .sd       (sd)
);

// File: tb/sim_spi_panel_tx.sv
`timescale 1ns/1ps
module sim_spi_panel_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic [2:0]  cfg_fmt;
  logic        cfg_cpol, cfg_cpha;
  logic [2:0]  cfg_lead, cfg_trail;
  logic        in_valid, in_is_cmd;
  logic [31:0] in_data;
  logic        in_ready, cs_n, sclk, dc;
  logic [3:0]  sd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_panel_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fmt(cfg_fmt),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail),
    .in_valid(in_valid), .in_is_cmd(in_is_cmd), .in_data(in_data), .in_ready(in_ready),
    .cs_n(cs_n), .sclk(sclk), .dc(dc), .sd(sd)
  );

  // expected and observed beats
  logic [3:0] exp_q[$];
  logic       exp_dc_q[$];
  logic [3:0] obs_q[$];
  logic       obs_dc_q[$];

  // monitor state
  int  cyc = 0;
  logic sclk_p = 1'b0, cs_p = 1'b1;
  int  t_fall = 0, t_last = 0, lead_meas = -1, trail_meas = -1;
  bit  first_pend = 0, have_cap = 0;
  int  t_cap = 0, space_bad = 0, falls = 0, rdy_act = 0, idle_sd_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cs_p && !cs_n) begin
        t_fall = cyc; first_pend = 1; have_cap = 0; falls++;
      end
      if (sclk != sclk_p) begin
        if (first_pend && !cs_n) begin
          lead_meas = cyc - t_fall; first_pend = 0;
        end
        if (!cs_p) t_last = cyc;
        if (!cs_n && ((cfg_cpha == 1'b0 && sclk_p == cfg_cpol) ||
                      (cfg_cpha == 1'b1 && sclk_p != cfg_cpol))) begin
          obs_q.push_back(sd);
          obs_dc_q.push_back(dc);
          if (have_cap && (cyc - t_cap) != 2) space_bad++;
          have_cap = 1; t_cap = cyc;
        end
      end
      if (!cs_p && cs_n) trail_meas = cyc - t_last;
      if (in_ready && !cs_n) rdy_act++;
      if (cs_n && sd != 4'b0) idle_sd_bad++;
      sclk_p = sclk; cs_p = cs_n;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] f);
    case (f)
      3'd0: return 3;
      3'd1: return 8;
      3'd2: return 12;
      3'd3: return 16;
      3'd4: return 18;
      default: return 24;
    endcase
  endfunction

  // builds the expected wire beats of one word from the requirements
  task automatic expect_word(input bit c, input logic [31:0] d);
    bit bl[$];
    int w, L, nb;
    w = width_of(cfg_fmt);
    L = 1;
    if (c) begin
      if (cfg_mode == 2'd3) begin
        for (int i = 31; i >= 0; i--) bl.push_back(d[i]);
      end else begin
        if (cfg_mode != 2'd1) bl.push_back(1'b0);
        for (int i = 7; i >= 0; i--) bl.push_back(d[i]);
      end
    end else begin
      if (cfg_mode == 2'd0) bl.push_back(1'b1);
      for (int i = w - 1; i >= 0; i--) bl.push_back(d[i]);
      if (cfg_mode == 2'd2) L = 2;
      if (cfg_mode == 2'd3) L = 4;
    end
    nb = (bl.size() + L - 1) / L;
    for (int k = 0; k < nb; k++) begin
      logic [3:0] v;
      v = 4'b0;
      for (int j = 0; j < L; j++) begin
        int p;
        p = k * L + (L - 1 - j);
        if (p < bl.size()) v[j] = bl[p];
      end
      exp_q.push_back(v);
      exp_dc_q.push_back(!c);
    end
  endtask

  task automatic send_word(input bit c, input logic [31:0] d);
    in_is_cmd = c; in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [2:0] f, input logic pl,
                         input logic ph, input logic [2:0] ld, input logic [2:0] tr);
    cfg_mode = m; cfg_fmt = f; cfg_cpol = pl; cfg_cpha = ph; cfg_lead = ld; cfg_trail = tr;
    repeat (3) @(negedge clk);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // runs one burst of words and checks the whole chip-select window
  task automatic run_burst(input int nw, input bit cmds[$], input logic [31:0] ds[$]);
    string tg;
    int mism, dcm;
    exp_q.delete(); exp_dc_q.delete(); obs_q.delete(); obs_dc_q.delete();
    falls = 0; rdy_act = 0; space_bad = 0; idle_sd_bad = 0;
    lead_meas = -1; trail_meas = -1;
    for (int i = 0; i < nw; i++) begin
      expect_word(cmds[i], ds[i]);
      send_word(cmds[i], ds[i]);
    end
    in_valid = 1'b0;
    while (!cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
    tg = mode_tag(cfg_mode);
    check(obs_q.size() == exp_q.size(), tg, "beat count", obs_q.size(), exp_q.size());
    mism = -1; dcm = -1;
    if (obs_q.size() == exp_q.size()) begin
      for (int i = 0; i < exp_q.size(); i++) begin
        if (mism < 0 && obs_q[i] !== exp_q[i]) mism = i;
        if (dcm < 0 && obs_dc_q[i] !== exp_dc_q[i]) dcm = i;
      end
    end
    check(mism < 0, tg, "beat value", (mism < 0) ? 0 : int'(obs_q[mism]),
          (mism < 0) ? 0 : int'(exp_q[mism]));
    check(dcm < 0, "R3", "dc per beat first mismatch index", dcm, -1);
    check(falls == 1, "R10", "cs_n falls per burst", falls, 1);
    check(lead_meas == 2 * cfg_lead + (cfg_cpha ? 0 : 1), "R8", "setup cycles",
          lead_meas, 2 * cfg_lead + (cfg_cpha ? 0 : 1));
    check(trail_meas == 2 * cfg_trail + (cfg_cpha ? 1 : 0), "R9", "hold cycles",
          trail_meas, 2 * cfg_trail + (cfg_cpha ? 1 : 0));
    check(space_bad == 0, "R7", "bad sampling spacings", space_bad, 0);
    check(sclk == cfg_cpol, "R7", "idle sclk level", sclk, cfg_cpol);
    check(rdy_act == nw, "R11", "ready cycles inside window", rdy_act, nw);
    check(idle_sd_bad == 0 && sd == 4'b0, "R12", "idle lane activity", idle_sd_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit          cs[$];
    logic [31:0] dq[$];
    int          seed;
    seed = $urandom(32'd7781);
    rst_n = 1'b0; in_valid = 1'b0; in_is_cmd = 1'b0; in_data = '0;
    cfg_mode = 2'd0; cfg_fmt = 3'd0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_lead = 3'd0; cfg_trail = 3'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
    check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    check(sd == 4'b0, "R1", "sd after reset", sd, 0);
    check(dc == 1'b1, "R1", "dc after reset", dc, 1);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R2 3-wire command and data with garbage above the pixel width
    set_cfg(2'd0, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0);
    cs = {1'b1}; dq = {32'h0000_00A5}; run_burst(1, cs, dq);
    cs = {1'b0}; dq = {32'hFFFF_FFF5}; run_burst(1, cs, dq);
    // R3 4-wire command then data back to back
    set_cfg(2'd1, 3'd3, 1'b0, 1'b1, 3'd1, 3'd2);
    cs = {1'b1, 1'b0}; dq = {32'h0000_002C, 32'h1234_BEEF}; run_burst(2, cs, dq);
    // R4 dual command then 18-bit data (odd beat count)
    set_cfg(2'd2, 3'd4, 1'b1, 1'b0, 3'd0, 3'd1);
    cs = {1'b1, 1'b0, 1'b0}; dq = {32'h0000_0039, 32'h0002_A5C3, 32'hFFF3_5A3C};
    run_burst(3, cs, dq);
    // R5 quad command then 18-bit data padded on the last beat
    set_cfg(2'd3, 3'd4, 1'b1, 1'b1, 3'd7, 3'd7);
    cs = {1'b1, 1'b0}; dq = {32'h02_00_2C_00, 32'h0003_1F0E}; run_burst(2, cs, dq);
    // R8 R9 extremes on a single-lane link
    set_cfg(2'd1, 3'd1, 1'b0, 1'b0, 3'd7, 3'd0);
    cs = {1'b0}; dq = {32'h0000_0081}; run_burst(1, cs, dq);
    // R6 every width code through the 4-wire mode
    for (int f = 0; f < 8; f++) begin
      set_cfg(2'd1, 3'(f), 1'b0, 1'b0, 3'd0, 3'd0);
      cs = {1'b0}; dq = {32'hDEAD_BEEF ^ 32'(f)};
      run_burst(1, cs, dq);
      check(obs_q.size() == width_of(3'(f)), "R6", "bits per pixel", obs_q.size(), width_of(3'(f)));
    end
    // random bursts
    for (int b = 0; b < 30; b++) begin
      int nw;
      set_cfg(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
      nw = $urandom_range(1, 4);
      cs.delete(); dq.delete();
      for (int i = 0; i < nw; i++) begin
        cs.push_back(1'($urandom_range(0, 1)));
        dq.push_back($urandom);
      end
      run_burst(nw, cs, dq);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule